// File: doc/BRIEF.md
# Pattern-Masked Write Data Deserializer

This block collects one write data packet that arrives serially on sixteen lanes over sixteen clocks. It rebuilds the 32-byte word and produces one write-enable bit per byte. Each write command comes with a flag that selects masked or unmasked mode, and with an 8-bit reserved pattern. In masked mode, any received byte whose value equals the pattern is marked as not to be written. In unmasked mode every byte is written.

A command is a one-cycle strobe. Its data packet starts a programmable number of clocks after the strobe. That delay is taken from a configuration input while reset is held. At most two commands may be pending at once. Each pending command keeps its own mode flag and its own pattern, so two writes issued sixteen clocks apart stream their packets back to back without losing either mask.

Top module: `pmw_deser`

## Requirements
- R1: While reset is high, and after it falls, `wr_data`, `wr_be` and `wr_done` are all zero until the first packet completes.
- R2: Lane n, for n from 0 to 15, carries data byte n during the first eight bit times of a packet and byte 16+n during the last eight. Byte b sits in `wr_data[8b+7:8b]`.
- R3: Within each byte, bit 0 is received first and bit 7 last.
- R4: For a masked command, a byte equal to the command's pattern has its `wr_be` bit at 0, and every other byte has its bit at 1. Bit i of the pattern is compared with bit i of the byte.
- R5: For an unmasked command, all 32 `wr_be` bits are 1, even for bytes equal to the pattern.
- R6: `cfg_delay` is sampled while reset is high, and a value of 0 is treated as 1. With a strobe at clock edge t and a delay of D, the first bit of the packet is sampled at edge t+D, and one bit per lane is sampled on each of the following fifteen edges.
- R7: `wr_done` is high for exactly one cycle, starting at the edge that samples the last bit. `wr_data` and `wr_be` update at that same edge and hold their values until the next completion.
- R8: Two commands with strobes 16 clocks apart produce two consecutive packets. Each packet is completed with the mode and pattern of its own command.
- R9: Masked and unmasked commands follow identical packet timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the delay |
| cmd_valid | input | 1 | One-cycle write command strobe |
| cmd_masked | input | 1 | 1 = masked write, 0 = unmasked |
| cmd_pattern | input | 8 | Reserved byte value that marks a byte as not written |
| cfg_delay | input | 8 | Clocks from strobe to first data bit, sampled in reset |
| lane_in | input | 16 | One serial bit per lane per clock |
| wr_data | output | 256 | Assembled packet, byte b at bits 8b+7..8b |
| wr_be | output | 32 | Per-byte write enable |
| wr_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is two commands in flight together. The second command's countdown runs while the first packet is still shifting in, and the queue shifts at the same edge on which a strobe may push. The bench reaches this case by forking two packet drivers whose strobes are exactly sixteen clocks apart. It gives the two commands different modes and patterns, so that swapped or lost mask state shows up in the enables. It repeats this at the shortest delay of one clock and at longer delays.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              masked;
        logic [BYTE_W-1:0] pat;
    } wr_mode_t;
endpackage

// File: rtl/pmw_cmd_queue.sv
module pmw_cmd_queue import pmw_pkg::*; #(
    parameter int DLY_W = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             push_i,
    input  wr_mode_t         mode_i,
    input  logic             pop_i,
    output logic             head_ready_o,
    output wr_mode_t         head_mode_o
);
    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        wr_mode_t [DEPTH-1:0]        mode;
        logic [DEPTH-1:0][DLY_W-1:0] wcnt;
    } q_t;

    q_t   q_d, q_q;
    logic placed;

    always_comb begin
        q_d    = q_q;
        placed = 1'b0;
        // every pending entry counts down towards its capture slot
        for (int i = 0; i < DEPTH; i++) begin
            if (q_q.vld[i] && q_q.wcnt[i] != '0) begin
                q_d.wcnt[i] = q_q.wcnt[i] - 1'b1;
            end
        end
        if (pop_i) begin
            for (int i = 0; i < DEPTH-1; i++) begin
                q_d.vld[i]  = q_d.vld[i+1];
                q_d.mode[i] = q_d.mode[i+1];
                q_d.wcnt[i] = q_d.wcnt[i+1];
            end
            q_d.vld[DEPTH-1] = 1'b0;
        end
        // a strobe that finds no free slot is dropped
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !q_d.vld[i]) begin
                    q_d.vld[i]  = 1'b1;
                    q_d.mode[i] = mode_i;
                    q_d.wcnt[i] = dly_i - 1'b1;
                    placed      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    assign head_ready_o = q_q.vld[0] && (q_q.wcnt[0] == '0);
    assign head_mode_o  = q_q.mode[0];
endmodule

// File: rtl/pmw_byte_mask.sv
module pmw_byte_mask import pmw_pkg::*; #(
    parameter int NBYTES = 32
) (
    input  logic [NBYTES*BYTE_W-1:0] data_i,
    input  wr_mode_t                 mode_i,
    output logic [NBYTES-1:0]        be_o
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign be_o[b] = !(mode_i.masked && (data_i[b*BYTE_W +: BYTE_W] == mode_i.pat));
    end
endmodule

// File: rtl/pmw_deser.sv
module pmw_deser import pmw_pkg::*; #(
    parameter  int LANES     = 16,
    parameter  int LANE_BITS = 16,
    parameter  int DLY_W     = 8,
    parameter  int QDEPTH    = 2,
    localparam int NBYTES    = LANES * LANE_BITS / BYTE_W,
    localparam int DATA_W    = LANES * LANE_BITS,
    localparam int CNT_W     = $clog2(LANE_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_masked,
    input  logic [BYTE_W-1:0] cmd_pattern,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [LANES-1:0]  lane_in,
    output logic [DATA_W-1:0] wr_data,
    output logic [NBYTES-1:0] wr_be,
    output logic              wr_done
);
    typedef struct packed {
        logic [DLY_W-1:0]                  dly;
        logic [CNT_W-1:0]                  bcnt;
        logic [LANES-1:0][LANE_BITS-1:0]   sh;
        logic [DATA_W-1:0]                 data;
        logic [NBYTES-1:0]                 be;
        logic                              done;
    } st_t;

    st_t                             s_d, s_q;
    logic [LANES-1:0][LANE_BITS-1:0] sh_nx;
    logic [DATA_W-1:0]               asm_w;
    logic [NBYTES-1:0]               be_nx;
    logic                            head_ready;
    logic                            last_bit;
    wr_mode_t                        head_mode;
    wr_mode_t                        cmd_mode;

    always_comb begin
        cmd_mode.masked = cmd_masked;
        cmd_mode.pat    = cmd_pattern;
    end

    pmw_cmd_queue #(.DLY_W(DLY_W), .DEPTH(QDEPTH)) u_queue (
        .clk          (clk),
        .rst          (rst),
        .dly_i        (s_q.dly),
        .push_i       (cmd_valid),
        .mode_i       (cmd_mode),
        .pop_i        (last_bit),
        .head_ready_o (head_ready),
        .head_mode_o  (head_mode)
    );

    // lane registers fill from the top so bit k of a lane ends at index k
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            sh_nx[l] = {lane_in[l], s_q.sh[l][LANE_BITS-1:1]};
        end
    end

    // bit k of lane l belongs to byte (k/8)*LANES + l, bit position k%8
    always_comb begin
        asm_w = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < LANE_BITS; k++) begin
                asm_w[((k / BYTE_W) * LANES + l) * BYTE_W + (k % BYTE_W)] = sh_nx[l][k];
            end
        end
    end

    pmw_byte_mask #(.NBYTES(NBYTES)) u_mask (
        .data_i (asm_w),
        .mode_i (head_mode),
        .be_o   (be_nx)
    );

    assign last_bit = head_ready && (s_q.bcnt == CNT_W'(LANE_BITS - 1));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (head_ready) begin
            s_d.sh   = sh_nx;
            s_d.bcnt = s_q.bcnt + 1'b1;
            if (last_bit) begin
                s_d.bcnt = '0;
                s_d.done = 1'b1;
                s_d.data = asm_w;
                s_d.be   = be_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.dly <= (cfg_delay == '0) ? DLY_W'(1) : cfg_delay;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_data = s_q.data;
    assign wr_be   = s_q.be;
    assign wr_done = s_q.done;
endmodule

// File: rtl/pmw_deser_chk.sv
module pmw_deser_chk #(
    parameter int NBYTES = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_done,
    input logic [NBYTES-1:0]   wr_be,
    input logic [NBYTES*8-1:0] wr_data,
    input logic                hd_masked,
    input logic [7:0]          hd_pat
);
    // R1: reset clears every output
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!wr_done && wr_be == '0 && wr_data == '0));

    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);

    // R7: results hold between completions
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_done && !$past(rst)) |-> ($stable(wr_data) && $stable(wr_be)));

    // R5: an unmasked packet enables every byte
    a_r5_unmasked_all: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !$past(hd_masked)) |-> (wr_be == '1));

    // R4: a masked packet clears exactly the bytes equal to the pattern
    for (genvar b = 0; b < NBYTES; b++) begin : g_r4
        a_r4_byte_match: assert property (@(posedge clk) disable iff (rst)
            (wr_done && $past(hd_masked)) |->
            (wr_be[b] == (wr_data[b*8 +: 8] != $past(hd_pat))));
    end
endmodule

bind pmw_deser pmw_deser_chk #(.NBYTES(NBYTES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_done   (wr_done),
    .wr_be     (wr_be),
    .wr_data   (wr_data),
    .hd_masked (head_mode.masked),
    .hd_pat    (head_mode.pat)
);

// File: tb/pmw_deser_tb_top.sv
module pmw_deser_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_masked = 1'b0;
    logic [7:0]   cmd_pattern = '0;
    logic [7:0]   cfg_delay = 8'd3;
    logic [15:0]  lane_in = '0;
    logic [255:0] wr_data;
    logic [31:0]  wr_be;
    logic         wr_done;

    int checks = 0;
    int errors = 0;
    int cur_d  = 3;

    always #10 clk = ~clk;

    pmw_deser dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_masked(cmd_masked),
        .cmd_pattern(cmd_pattern), .cfg_delay(cfg_delay), .lane_in(lane_in),
        .wr_data(wr_data), .wr_be(wr_be), .wr_done(wr_done)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_be(input bit m, input logic [7:0] p, input logic [255:0] d);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) r[b] = !(m && d[b*8 +: 8] == p);
        return r;
    endfunction

    function automatic logic [15:0] lane_word(input logic [255:0] d, input int k);
        logic [15:0] r;
        for (int l = 0; l < 16; l++) r[l] = d[((k / 8) * 16 + l) * 8 + (k % 8)];
        return r;
    endfunction

    task automatic do_reset(input logic [7:0] dly);
        rst = 1'b1;
        cfg_delay = dly;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(wr_done == 1'b0 && wr_be == '0 && wr_data == '0, "R1 outputs in reset",
              {wr_done, wr_be, wr_data[222:0]}, '0);
        rst = 1'b0;
        cur_d = (dly == 0) ? 1 : int'(dly);
        @(negedge clk);
        check(wr_done == 1'b0 && wr_be == '0 && wr_data == '0, "R1 outputs after reset",
              {wr_done, wr_be, wr_data[222:0]}, '0);
    endtask

    // called at a negedge; the strobe is taken at the next rising edge
    task automatic run_pkt(input bit m, input logic [7:0] p, input logic [255:0] d, input string tag);
        cmd_valid = 1'b1;
        cmd_masked = m;
        cmd_pattern = p;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (cur_d - 1) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            if (k == 15) check(wr_done == 1'b0, {tag, " R6 R9 done early"}, 256'(wr_done), 256'(0));
            lane_in = lane_word(d, k);
            @(negedge clk);
        end
        check(wr_done == 1'b1, {tag, " R6 R7 R9 done timing"}, 256'(wr_done), 256'(1));
        check(wr_data == d, {tag, " R2 R3 data"}, wr_data, d);
        check(wr_be == exp_be(m, p, d), {tag, m ? " R4 enables" : " R5 enables"},
              256'(wr_be), 256'(exp_be(m, p, d)));
        @(negedge clk);
        check(wr_done == 1'b0 && wr_data == d, {tag, " R7 pulse/hold"},
              {255'(wr_data[254:0]), wr_done}, {255'(d[254:0]), 1'b0});
    endtask

    function automatic logic [255:0] rnd_pkt(input logic [7:0] p);
        logic [255:0] r;
        for (int b = 0; b < 32; b++) r[b*8 +: 8] = ($urandom % 4 == 0) ? p : 8'($urandom);
        return r;
    endfunction

    task automatic pair(input bit m1, input logic [7:0] p1, input bit m2, input logic [7:0] p2, input string tag);
        logic [255:0] d1, d2;
        d1 = rnd_pkt(p1);
        d2 = rnd_pkt(p2);
        fork
            run_pkt(m1, p1, d1, {tag, " R8 first"});
            begin
                repeat (16) @(negedge clk);
                run_pkt(m2, p2, d2, {tag, " R8 second"});
            end
        join
    endtask

    initial begin
        logic [255:0] d;
        void'($urandom(32'hC0FFEE));
        do_reset(8'd3);

        // R3: distinct byte values expose bit order
        for (int b = 0; b < 32; b++) d[b*8 +: 8] = 8'(b * 8 + 1);
        run_pkt(1'b0, 8'h00, d, "R3 ramp");
        // R5: unmasked with every byte equal to the pattern
        run_pkt(1'b0, 8'h5A, {32{8'h5A}}, "R5 all equal");
        // R4: masked, every byte equal, then none equal, then off by bit 0
        run_pkt(1'b1, 8'h5A, {32{8'h5A}}, "R4 all masked");
        run_pkt(1'b1, 8'h5A, {32{8'hA5}}, "R4 none masked");
        run_pkt(1'b1, 8'h80, {16{8'h80, 8'h81}}, "R4 near miss");

        // constrained random, sequential
        for (int i = 0; i < 20; i++) begin
            logic [7:0] p;
            p = 8'($urandom);
            run_pkt(1'($urandom), p, rnd_pkt(p), "R4 R5 random");
        end

        // R8: back to back with different modes and patterns
        pair(1'b1, 8'h3C, 1'b0, 8'h3C, "b2b m/u");
        pair(1'b1, 8'h11, 1'b1, 8'hEE, "b2b m/m");

        // R6: a longer delay, then delay 0 treated as 1
        do_reset(8'd7);
        run_pkt(1'b1, 8'h42, rnd_pkt(8'h42), "R6 delay7");
        pair(1'b0, 8'h00, 1'b1, 8'h42, "R6 delay7");
        do_reset(8'd0);
        run_pkt(1'b1, 8'hFF, rnd_pkt(8'hFF), "R6 delay0");
        pair(1'b1, 8'h01, 1'b1, 8'h02, "R6 delay0");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule